// File: doc/BRIEF.md
# Integer Load/Store Execution Unit

This unit carries out integer loads, stores and load-multiple operations for a RISC core with a 32-entry, 32-bit general register file. A decoded operation enters on a valid/ready port. The unit reads the base, index and store-source registers through three combinational read ports. It forms a byte address and issues one request per memory word on a big-endian, byte-lane-enabled 32-bit memory port. It writes load results back through a single register write port. The address is a base register plus either a sign-extended immediate or a second index register. A base field of zero stands for a literal zero, not for the contents of register 0.

Loads of a byte, a half-word or a word are taken from the lane that the low address bits select. A narrow value is zero-filled or sign-extended, and a half-word load can exchange its two bytes first. Stores place the low byte, half-word or word of the source register on the matching lanes and enable only those lanes. A load-multiple operation fills every register from the named destination through r31, one word per register, at ascending addresses. An access that is not aligned to its size is refused with a one-cycle error pulse.

Back-pressure rules: the unit accepts an operation only in a cycle where `op_valid` and `op_ready` are both high. `op_ready` stays low from the cycle after an accepted access until its last memory transfer completes. On the memory side, `mem_req` and every request field stay constant until the cycle in which `mem_ready` is high, and that cycle completes the transfer. Read data is taken from `mem_rdata` in that same cycle.

Top module: `lsu_top`

## Requirements
- R1: In displacement form (`op_indexed`=0) the effective address is the base register value plus `op_imm` sign-extended to 32 bits, with wraparound modulo 2^32.
- R2: When `op_ra` is 0, the base value is zero, whatever register 0 holds.
- R3: In indexed form (`op_indexed`=1) the value of register `op_rb` replaces the sign-extended immediate in the address sum, for loads and for stores.
- R4: `op_size` encodes 0 = byte, 1 = half-word, 2 or 3 = word. Memory is big-endian. The byte at address offset k (k = address bits [1:0]) sits on `mem_rdata`/`mem_wdata` bits [31-8k:24-8k], enabled by `mem_be` bit 3-k. A half-word at offset 0 uses bits [31:16] and at offset 2 uses bits [15:0]. `mem_be` has exactly the lanes of the access set.
- R5: A byte or half-word load zero-fills the upper bits when `op_signed`=0 and sign-extends from the top bit of the value when `op_signed`=1.
- R6: With `op_swap`=1, a half-word load exchanges the two fetched bytes before extension, so extension uses the bit that ends up on top. For byte and word loads `op_swap` has no effect.
- R7: `op_kind` encodes 0 = load, 1 = store, 2 = load-multiple, and 3 behaves as a load. A store writes the low byte, half-word or word of register `op_rd` to the addressed bytes only, leaves the other bytes of the word unchanged, and writes no register.
- R8: A load-multiple with destination rN loads rN, rN+1, ... r31 from consecutive words, starting at the effective address and stepping by 4. `op_size` is ignored, and registers below rN are not written.
- R9: `busy` is high and `op_ready` is low from the cycle after an accepted aligned operation until the edge at which its last transfer completes. No other operation is accepted in that time.
- R10: A half-word access at an odd address, a word access, or a load-multiple, at an address that is not a multiple of 4, raises `align_err` for exactly the one cycle after acceptance. It issues no memory request and writes no register.
- R11: While `mem_req` is high and `mem_ready` is low, the request (address, byte enables, write data, direction) holds steady. Each transfer completes in a cycle where `mem_ready` is high, so stalls only stretch the operation.
- R12: After reset `busy`, `mem_req`, `rf_we` and `align_err` are low and `op_ready` is high. `rf_we` is high only in a cycle that completes a load transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Decoded operation present |
| op_ready | output | 1 | Unit can accept an operation |
| op_kind | input | 2 | 0 load, 1 store, 2 load-multiple, 3 as load |
| op_size | input | 2 | 0 byte, 1 half-word, 2/3 word |
| op_signed | input | 1 | Sign-extend narrow load |
| op_swap | input | 1 | Exchange bytes of a half-word load |
| op_indexed | input | 1 | Use index register instead of immediate |
| op_rd | input | 5 | Destination (load) or source (store) register |
| op_ra | input | 5 | Base register, 0 means literal zero |
| op_rb | input | 5 | Index register |
| op_imm | input | 16 | Signed displacement |
| ra_idx | output | 5 | Register read port A address (base) |
| ra_data | input | 32 | Register read port A data |
| rb_idx | output | 5 | Register read port B address (index) |
| rb_data | input | 32 | Register read port B data |
| rs_idx | output | 5 | Register read port C address (store source) |
| rs_data | input | 32 | Register read port C data |
| rf_we | output | 1 | Register write enable |
| rf_waddr | output | 5 | Register write address |
| rf_wdata | output | 32 | Register write data |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the access |
| mem_be | output | 4 | Byte-lane enables, bit i for bits [8i+7:8i] |
| mem_wdata | output | 32 | Write data on the enabled lanes |
| mem_ready | input | 1 | Memory completes the request this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| busy | output | 1 | An access or load-multiple is in progress |
| align_err | output | 1 | One-cycle pulse for a refused misaligned access |

## Verification
The bench builds the unit with its defaults: 32-bit data, 32 registers and a 16-bit displacement. With these, negative offsets can pull an address below its base, and a base field of zero is told apart from register 0, which holds a nonzero value. With 32 registers, a load-multiple from r28 runs four steps to the top of the file, so the stepping, the end at r31 and the untouched r27 can all be observed. A memory that alternates its ready signal shows that stalls stretch accesses without changing their results.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

  typedef enum logic [1:0] {
    K_LOAD  = 2'd0,
    K_STORE = 2'd1,
    K_LMW   = 2'd2,
    K_RSVD  = 2'd3
  } kind_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WRD2 = 2'd3
  } size_e;

  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_ACCESS = 1'b1
  } state_e;

endpackage

// File: rtl/lsu_agen.sv
module lsu_agen #(
  parameter int XLEN   = 32,
  parameter int IMM_W  = 16,
  parameter int RIDX_W = 5
) (
  input  logic [RIDX_W-1:0] base_idx,
  input  logic [XLEN-1:0]   base_val,
  input  logic [XLEN-1:0]   index_val,
  input  logic [IMM_W-1:0]  imm,
  input  logic              use_index,
  output logic [XLEN-1:0]   ea
);

  logic [XLEN-1:0] base_eff;
  logic [XLEN-1:0] disp;

  // a zero base field selects the constant zero
  assign base_eff = (base_idx == '0) ? '0 : base_val;
  assign disp     = use_index ? index_val
                              : {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
  assign ea       = base_eff + disp;

endmodule

// File: rtl/lsu_lane.sv
module lsu_lane
  import lsu_pkg::*;
#(
  parameter  int XLEN  = 32,
  localparam int NB    = XLEN / 8,
  localparam int OFF_W = $clog2(NB)
) (
  input  logic [OFF_W-1:0] off,
  input  size_e            size,
  input  logic [XLEN-1:0]  src,
  output logic [NB-1:0]    be,
  output logic [XLEN-1:0]  wdata,
  output logic             misaligned
);

  int unsigned lane_b;
  int unsigned lane_h;

  always_comb begin
    lane_b     = NB - 1 - int'(off);
    lane_h     = NB - 2 - int'(off);
    misaligned = 1'b0;
    be         = '0;
    wdata      = '0;
    unique case (size)
      SZ_BYTE: begin
        be    = NB'(1) << lane_b;
        wdata = XLEN'(src[7:0]) << (8 * lane_b);
      end
      SZ_HALF: begin
        misaligned = off[0];
        if (!off[0]) begin
          be    = NB'(3) << lane_h;
          wdata = XLEN'(src[15:0]) << (8 * lane_h);
        end
      end
      default: begin
        misaligned = (off != '0);
        if (off == '0) begin
          be    = '1;
          wdata = src;
        end
      end
    endcase
  end

endmodule

// File: rtl/lsu_extract.sv
module lsu_extract
  import lsu_pkg::*;
#(
  parameter  int XLEN  = 32,
  localparam int NB    = XLEN / 8,
  localparam int OFF_W = $clog2(NB)
) (
  input  logic [XLEN-1:0]  rdata,
  input  logic [OFF_W-1:0] off,
  input  size_e            size,
  input  logic             sgn,
  input  logic             swp,
  output logic [XLEN-1:0]  value
);

  logic [7:0]  b_raw;
  logic [15:0] h_raw;
  logic [15:0] h_ord;
  int unsigned sh_b;
  int unsigned sh_h;

  always_comb begin
    sh_b  = 8 * (NB - 1 - int'(off));
    sh_h  = 8 * (NB - 2 - int'(off));
    b_raw = 8'(rdata >> sh_b);
    h_raw = (off[0]) ? 16'h0 : 16'(rdata >> sh_h);
    h_ord = swp ? {h_raw[7:0], h_raw[15:8]} : h_raw;
    unique case (size)
      SZ_BYTE: value = sgn ? {{(XLEN-8){b_raw[7]}}, b_raw} : XLEN'(b_raw);
      SZ_HALF: value = sgn ? {{(XLEN-16){h_ord[15]}}, h_ord} : XLEN'(h_ord);
      default: value = rdata;
    endcase
  end

endmodule

// File: rtl/lsu_top.sv
module lsu_top
  import lsu_pkg::*;
#(
  parameter  int XLEN   = 32,
  parameter  int NREG   = 32,
  parameter  int IMM_W  = 16,
  localparam int RIDX_W = $clog2(NREG),
  localparam int NB     = XLEN / 8,
  localparam int OFF_W  = $clog2(NB)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  output logic              op_ready,
  input  logic [1:0]        op_kind,
  input  logic [1:0]        op_size,
  input  logic              op_signed,
  input  logic              op_swap,
  input  logic              op_indexed,
  input  logic [RIDX_W-1:0] op_rd,
  input  logic [RIDX_W-1:0] op_ra,
  input  logic [RIDX_W-1:0] op_rb,
  input  logic [IMM_W-1:0]  op_imm,
  output logic [RIDX_W-1:0] ra_idx,
  input  logic [XLEN-1:0]   ra_data,
  output logic [RIDX_W-1:0] rb_idx,
  input  logic [XLEN-1:0]   rb_data,
  output logic [RIDX_W-1:0] rs_idx,
  input  logic [XLEN-1:0]   rs_data,
  output logic              rf_we,
  output logic [RIDX_W-1:0] rf_waddr,
  output logic [XLEN-1:0]   rf_wdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [XLEN-1:0]   mem_addr,
  output logic [NB-1:0]     mem_be,
  output logic [XLEN-1:0]   mem_wdata,
  input  logic              mem_ready,
  input  logic [XLEN-1:0]   mem_rdata,
  output logic              busy,
  output logic              align_err
);

  localparam logic [RIDX_W-1:0] LAST_REG = RIDX_W'(NREG - 1);
  localparam logic [XLEN-1:0]   STEP     = XLEN'(NB);

  kind_e in_kind;
  size_e in_size;
  logic [XLEN-1:0] ea;
  logic [NB-1:0]   be_n;
  logic [XLEN-1:0] wd_n;
  logic            mis_n;
  logic            accept;

  state_e            state_q;
  kind_e             kind_q;
  size_e             size_q;
  logic              sgn_q;
  logic              swp_q;
  logic [RIDX_W-1:0] rd_q;
  logic [XLEN-1:0]   addr_q;
  logic [NB-1:0]     be_q;
  logic [XLEN-1:0]   wd_q;
  logic              err_q;
  logic              last_step;
  logic [XLEN-1:0]   ld_value;

  // operand reads come straight from the offered operation
  assign ra_idx = op_ra;
  assign rb_idx = op_rb;
  assign rs_idx = op_rd;

  assign in_kind = kind_e'(op_kind);
  assign in_size = (in_kind == K_LMW) ? SZ_WORD : size_e'(op_size);

  lsu_agen #(.XLEN(XLEN), .IMM_W(IMM_W), .RIDX_W(RIDX_W)) u_agen (
    .base_idx  (op_ra),
    .base_val  (ra_data),
    .index_val (rb_data),
    .imm       (op_imm),
    .use_index (op_indexed),
    .ea        (ea)
  );

  lsu_lane #(.XLEN(XLEN)) u_lane (
    .off        (ea[OFF_W-1:0]),
    .size       (in_size),
    .src        (rs_data),
    .be         (be_n),
    .wdata      (wd_n),
    .misaligned (mis_n)
  );

  assign op_ready  = (state_q == ST_IDLE);
  assign accept    = op_valid && op_ready;
  assign last_step = (kind_q != K_LMW) || (rd_q == LAST_REG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      kind_q  <= K_LOAD;
      size_q  <= SZ_BYTE;
      sgn_q   <= 1'b0;
      swp_q   <= 1'b0;
      rd_q    <= '0;
      addr_q  <= '0;
      be_q    <= '0;
      wd_q    <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= accept && mis_n;
      unique case (state_q)
        ST_IDLE: begin
          if (accept && !mis_n) begin
            state_q <= ST_ACCESS;
            kind_q  <= (in_kind == K_RSVD) ? K_LOAD : in_kind;
            size_q  <= in_size;
            sgn_q   <= op_signed;
            swp_q   <= op_swap;
            rd_q    <= op_rd;
            addr_q  <= ea;
            be_q    <= be_n;
            wd_q    <= wd_n;
          end
        end
        default: begin
          if (mem_ready) begin
            if (last_step) begin
              state_q <= ST_IDLE;
            end else begin
              rd_q   <= rd_q + 1'b1;
              addr_q <= addr_q + STEP;
            end
          end
        end
      endcase
    end
  end

  lsu_extract #(.XLEN(XLEN)) u_extract (
    .rdata (mem_rdata),
    .off   (addr_q[OFF_W-1:0]),
    .size  (size_q),
    .sgn   (sgn_q),
    .swp   (swp_q),
    .value (ld_value)
  );

  assign busy      = (state_q == ST_ACCESS);
  assign mem_req   = busy;
  assign mem_we    = (kind_q == K_STORE);
  assign mem_addr  = addr_q;
  assign mem_be    = be_q;
  assign mem_wdata = wd_q;
  assign rf_we     = busy && mem_ready && (kind_q != K_STORE);
  assign rf_waddr  = rd_q;
  assign rf_wdata  = ld_value;
  assign align_err = err_q;

endmodule

// File: rtl/lsu_checker.sv
module lsu_checker #(
  parameter  int XLEN  = 32,
  localparam int NB    = XLEN / 8,
  localparam int OFF_W = $clog2(NB)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            mem_req,
  input logic            mem_we,
  input logic [XLEN-1:0] mem_addr,
  input logic [NB-1:0]   mem_be,
  input logic [XLEN-1:0] mem_wdata,
  input logic            mem_ready,
  input logic            rf_we,
  input logic            align_err
);

  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_be)
                                 && $stable(mem_wdata) && $stable(mem_we)));

  a_r10_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |-> (!mem_req && !rf_we));

  a_r7_store_no_rf: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> !rf_we);

  a_r4_lane_count: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2
                 || $countones(mem_be) == NB));

  a_r4_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && $countones(mem_be) == NB) |-> (mem_addr[OFF_W-1:0] == '0));

  a_r12_we_on_ready: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> (mem_req && mem_ready && !mem_we));

endmodule

bind lsu_top lsu_checker #(.XLEN(XLEN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_be    (mem_be),
  .mem_wdata (mem_wdata),
  .mem_ready (mem_ready),
  .rf_we     (rf_we),
  .align_err (align_err)
);

// File: tb/lsu_top_bench.sv
module lsu_top_bench;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [1:0]  kind;
    logic [1:0]  size;
    logic        sgn;
    logic        swp;
    logic        idx;
    logic [4:0]  rd;
    logic [4:0]  ra;
    logic [4:0]  rb;
    logic [15:0] imm;
  } vec_t;

  // load table: kind, size, sgn, swp, idx, rd, ra, rb, imm
  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 5'd20, 5'd1, 5'd0, 16'd3},     // R1 R4 byte off3
    '{2'd0, 2'd0, 1'b1, 1'b0, 1'b0, 5'd21, 5'd2, 5'd0, 16'hFFFB},  // R1 R5 negative offset
    '{2'd0, 2'd1, 1'b0, 1'b0, 1'b0, 5'd22, 5'd0, 5'd0, 16'd6},     // R2 zero base
    '{2'd0, 2'd1, 1'b1, 1'b0, 1'b0, 5'd23, 5'd3, 5'd0, 16'd2},     // R5 signed half
    '{2'd0, 2'd1, 1'b0, 1'b1, 1'b0, 5'd24, 5'd4, 5'd0, 16'd0},     // R6 swap half off0
    '{2'd0, 2'd1, 1'b1, 1'b1, 1'b0, 5'd25, 5'd5, 5'd0, 16'd2},     // R6 swap signed off2
    '{2'd0, 2'd2, 1'b0, 1'b0, 1'b1, 5'd26, 5'd1, 5'd9, 16'd0},     // R3 indexed negative
    '{2'd3, 2'd3, 1'b0, 1'b0, 1'b1, 5'd27, 5'd0, 5'd6, 16'd0},     // R2 R3 R7 kind3 as load
    '{2'd0, 2'd0, 1'b1, 1'b1, 1'b0, 5'd20, 5'd6, 5'd0, 16'd1},     // R6 swap ignored byte
    '{2'd0, 2'd2, 1'b1, 1'b1, 1'b0, 5'd21, 5'd8, 5'd0, 16'hFFF8}   // R6 swap ignored word
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  vec_t        opv = '0;
  logic        op_ready;
  logic [4:0]  ra_idx, rb_idx, rs_idx;
  logic [31:0] ra_data, rb_data, rs_data;
  logic        rf_we;
  logic [4:0]  rf_waddr;
  logic [31:0] rf_wdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_be;
  logic        mem_ready = 1'b1;
  logic        busy, align_err;
  logic        stall_en = 1'b0;

  logic [7:0]  mb   [0:255];
  logic [31:0] regs [0:31];

  int checks = 0;
  int errs   = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lsu_top u_lsu_top (
    .clk(clk), .rst_n(rst_n),
    .op_valid(op_valid), .op_ready(op_ready),
    .op_kind(opv.kind), .op_size(opv.size), .op_signed(opv.sgn),
    .op_swap(opv.swp), .op_indexed(opv.idx),
    .op_rd(opv.rd), .op_ra(opv.ra), .op_rb(opv.rb), .op_imm(opv.imm),
    .ra_idx(ra_idx), .ra_data(ra_data),
    .rb_idx(rb_idx), .rb_data(rb_data),
    .rs_idx(rs_idx), .rs_data(rs_data),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_be(mem_be), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .busy(busy), .align_err(align_err)
  );

  // register file model
  assign ra_data = regs[ra_idx];
  assign rb_data = regs[rb_idx];
  assign rs_data = regs[rs_idx];
  always @(posedge clk) if (rf_we) regs[rf_waddr] <= rf_wdata;

  // big-endian byte memory model
  logic [7:0] wbase;
  assign wbase = {mem_addr[7:2], 2'b00};
  assign mem_rdata = {mb[wbase], mb[8'(wbase + 8'd1)], mb[8'(wbase + 8'd2)], mb[8'(wbase + 8'd3)]};
  always @(posedge clk) begin
    if (mem_req && mem_ready && mem_we) begin
      if (mem_be[3]) mb[wbase]               <= mem_wdata[31:24];
      if (mem_be[2]) mb[8'(wbase + 8'd1)]    <= mem_wdata[23:16];
      if (mem_be[1]) mb[8'(wbase + 8'd2)]    <= mem_wdata[15:8];
      if (mem_be[0]) mb[8'(wbase + 8'd3)]    <= mem_wdata[7:0];
    end
  end

  always @(negedge clk) mem_ready <= stall_en ? ~mem_ready : 1'b1;

  function automatic logic [7:0] pat(input int a);
    return 8'(a * 37 + 5);
  endfunction

  task automatic mem_init;
    for (int a = 0; a < 256; a++) mb[a] = pat(a);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic logic [31:0] ea_of(input vec_t v);
    logic [31:0] b, d;
    b = (v.ra == 5'd0) ? 32'h0 : regs[v.ra];
    d = v.idx ? regs[v.rb] : {{16{v.imm[15]}}, v.imm};
    return b + d;
  endfunction

  function automatic logic [31:0] exp_load(input vec_t v, input logic [31:0] ea);
    logic [7:0]  a, b0;
    logic [15:0] h;
    a  = ea[7:0];
    b0 = mb[a];
    h  = {mb[a], mb[8'(a + 8'd1)]};
    if (v.size == 2'd0) return v.sgn ? {{24{b0[7]}}, b0} : {24'h0, b0};
    if (v.size == 2'd1) begin
      if (v.swp) h = {h[7:0], h[15:8]};
      return v.sgn ? {{16{h[15]}}, h} : {16'h0, h};
    end
    return {mb[a], mb[8'(a + 8'd1)], mb[8'(a + 8'd2)], mb[8'(a + 8'd3)]};
  endfunction

  logic err_seen;

  task automatic issue(input vec_t v);
    @(negedge clk);
    opv = v;
    op_valid = 1'b1;
    while (!op_ready) @(negedge clk);
    @(negedge clk);
    op_valid = 1'b0;
    err_seen = align_err;
  endtask

  task automatic wait_idle;
    while (busy) @(negedge clk);
  endtask

  function automatic vec_t mk(input logic [1:0] k, input logic [1:0] s, input logic idx,
                              input logic [4:0] rd, input logic [4:0] ra,
                              input logic [4:0] rb, input logic [15:0] imm);
    vec_t v;
    v = '0;
    v.kind = k; v.size = s; v.idx = idx; v.rd = rd; v.ra = ra; v.rb = rb; v.imm = imm;
    return v;
  endfunction

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errs++;
        checks++;
        $display("FAIL R11 watchdog actual=%0d expected=<100000 cycles", cycles);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] ea, expv, saved;
    for (int i = 0; i < 32; i++) regs[i] = 32'(i * 8);
    regs[0]  = 32'h40;
    regs[9]  = 32'hFFFF_FFFC;
    regs[12] = 32'hA1B2_C3D4;
    mem_init();
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 busy after reset", {31'h0, busy}, 32'h0);
    chk("R12 op_ready after reset", {31'h0, op_ready}, 32'h1);
    chk("R12 mem_req after reset", {31'h0, mem_req}, 32'h0);
    chk("R12 rf_we/align_err after reset", {30'h0, rf_we, align_err}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 idle after release", {30'h0, busy, mem_req}, 32'h0);

    // table of loads: R1 R2 R3 R4 R5 R6
    for (int n = 0; n < NVEC; n++) begin
      ea   = ea_of(VECS[n]);
      expv = exp_load(VECS[n], ea);
      issue(VECS[n]);
      wait_idle();
      chk($sformatf("R4/R5/R6 table row %0d", n), regs[VECS[n].rd], expv);
    end

    // R7 byte store at offset 1
    mem_init();
    issue(mk(2'd1, 2'd0, 1'b0, 5'd12, 5'd1, 5'd0, 16'd5));
    wait_idle();
    chk("R7 byte store lane", {24'h0, mb[13]}, 32'hD4);
    chk("R7 byte store neighbours", {mb[12], mb[14], mb[15], 8'h0},
        {pat(12), pat(14), pat(15), 8'h0});
    // R7 half store at offset 2
    issue(mk(2'd1, 2'd1, 1'b0, 5'd12, 5'd2, 5'd0, 16'd2));
    wait_idle();
    chk("R7 half store word", {mb[16], mb[17], mb[18], mb[19]},
        {pat(16), pat(17), 8'hC3, 8'hD4});
    // R3 R7 indexed word store 24+8
    issue(mk(2'd1, 2'd2, 1'b1, 5'd12, 5'd3, 5'd1, 16'd0));
    wait_idle();
    chk("R3 R7 indexed word store", {mb[32], mb[33], mb[34], mb[35]}, 32'hA1B2C3D4);

    // R11 stalled memory: store then load back
    stall_en = 1'b1;
    issue(mk(2'd1, 2'd2, 1'b0, 5'd12, 5'd0, 5'd0, 16'd64));
    wait_idle();
    chk("R11 stalled store", {mb[64], mb[65], mb[66], mb[67]}, 32'hA1B2C3D4);
    issue(mk(2'd0, 2'd1, 1'b0, 5'd19, 5'd0, 5'd0, 16'd66));
    wait_idle();
    chk("R11 stalled half load", regs[19], 32'h0000C3D4);
    stall_en = 1'b0;

    // R8 R9 load-multiple r28..r31 from 16+4
    mem_init();
    saved = regs[27];
    issue(mk(2'd2, 2'd0, 1'b0, 5'd28, 5'd2, 5'd0, 16'd4));
    chk("R9 busy during load-multiple", {30'h0, busy, op_ready}, 32'h2);
    wait_idle();
    chk("R9 ready after load-multiple", {31'h0, op_ready}, 32'h1);
    for (int r = 28; r < 32; r++) begin
      ea = 32'(20 + 4 * (r - 28));
      chk($sformatf("R8 load-multiple r%0d", r), regs[r],
          {pat(int'(ea)), pat(int'(ea) + 1), pat(int'(ea) + 2), pat(int'(ea) + 3)});
    end
    chk("R8 register below start untouched", regs[27], saved);

    // R8 R11 load-multiple under stalls from r30
    stall_en = 1'b1;
    issue(mk(2'd2, 2'd1, 1'b0, 5'd30, 5'd0, 5'd0, 16'd100));
    wait_idle();
    stall_en = 1'b0;
    chk("R8 R11 stalled load-multiple r30", regs[30], {pat(100), pat(101), pat(102), pat(103)});
    chk("R8 R11 stalled load-multiple r31", regs[31], {pat(104), pat(105), pat(106), pat(107)});

    // R10 misaligned accesses
    saved = regs[22];
    issue(mk(2'd0, 2'd1, 1'b0, 5'd22, 5'd1, 5'd0, 16'd1));
    chk("R10 odd half load flag", {31'h0, err_seen}, 32'h1);
    chk("R10 odd half load no busy", {31'h0, busy}, 32'h0);
    @(negedge clk);
    chk("R10 flag lasts one cycle", {31'h0, align_err}, 32'h0);
    chk("R10 odd half load no write", regs[22], saved);
    issue(mk(2'd1, 2'd2, 1'b0, 5'd12, 5'd2, 5'd0, 16'd2));
    chk("R10 misaligned word store flag", {31'h0, err_seen}, 32'h1);
    @(negedge clk);
    chk("R10 misaligned word store no write", {mb[16], mb[17], mb[18], mb[19]},
        {pat(16), pat(17), pat(18), pat(19)});
    saved = regs[29];
    issue(mk(2'd2, 2'd0, 1'b0, 5'd29, 5'd0, 5'd0, 16'd6));
    chk("R10 misaligned load-multiple flag", {31'h0, err_seen}, 32'h1);
    @(negedge clk);
    chk("R10 misaligned load-multiple no write", regs[29], saved);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule